// File: doc/BRIEF.md
# Dual Hardware Stack Unit

This block gives a 16-bit processor two independent on-chip stacks. The data stack keeps register values that software saves with a push and takes back with a pop. The call stack keeps return addresses, and software cannot reach it: a call stores the current program counter and sends the core to a target address. A return restores the stored address. Both stacks grow downward. A push or call writes at the pointer and then decrements it. A pop or return reads at pointer plus one and then increments it.

Commands come in as one-cycle strobes, one per cycle. The unit accepts every command in the cycle it is presented and never applies back-pressure. For that reason there is no ready signal. The results are registered and appear in the following cycle: popped data with `pop_valid`, and a new program counter with `pc_load`. These strobes are single-cycle and cannot be stalled. The consumer must take them in that cycle. The data stack pointer is also presented as the low byte of a read-only banked view, whose high byte is the current memory bank number. An overflow or underflow leaves the stack untouched and reports a one-cycle error.

Top module: `dual_stack_unit`

## Requirements
- R1: After reset, both pointers read 0xFF, `pop_data` and `pc_next` read 0, and `pop_valid`, `pc_load` and `err` are low.
- R2: A push (`cmd_op` = 0) with the data pointer not 0x00 stores `operand` at entry `dsp` and lowers `dsp` by one on the next cycle.
- R3: A pop (`cmd_op` = 1) with the data pointer not 0xFF raises `pop_valid` for one cycle on the next cycle, with `pop_data` equal to entry `dsp`+1, and raises `dsp` by one.
- R4: A call (`cmd_op` = 2) with the call pointer not 0x00 stores `cur_pc` at entry `csp`, lowers `csp` by one, and on the next cycle raises `pc_load` for one cycle with `pc_next` equal to `target`.
- R5: A return (`cmd_op` = 3) with the call pointer not 0xFF raises `pc_load` for one cycle on the next cycle, with `pc_next` equal to call entry `csp`+1, and raises `csp` by one.
- R6: A push with `dsp` = 0x00, or a call with `csp` = 0x00, raises `err` for one cycle on the next cycle. It leaves the pointer and the stored entries unchanged and gives no `pc_load`.
- R7: A pop with `dsp` = 0xFF, or a return with `csp` = 0xFF, raises `err` for one cycle on the next cycle. It gives neither `pop_valid` nor `pc_load`, and it leaves the pointer unchanged.
- R8: `bank_view` always equals {`bank_num`, `dsp`}. No input writes the data pointer except through push and pop.
- R9: A cycle with `cmd_valid` low changes no pointer, raises no strobe or error, and leaves `pop_data` and `pc_next` holding their previous values.
- R10: Data-stack commands never change `csp`, and call-stack commands never change `dsp` or `pop_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, always accepted |
| cmd_op | input | 2 | 0 push, 1 pop, 2 call, 3 return |
| operand | input | 16 | Value to push |
| cur_pc | input | 16 | Current program counter, saved by call |
| target | input | 16 | Call destination |
| bank_num | input | 8 | Memory bank number for the banked view |
| pop_data | output | 16 | Last popped value |
| pop_valid | output | 1 | One-cycle strobe: pop_data is new |
| pc_next | output | 16 | Program counter to load |
| pc_load | output | 1 | One-cycle strobe: load pc_next |
| err | output | 1 | One-cycle overflow or underflow flag |
| dsp | output | 8 | Data stack pointer |
| csp | output | 8 | Call stack pointer |
| bank_view | output | 16 | Read-only {bank, data pointer} |

## Verification
A wrong pointer in this unit becomes visible on `dsp` or `csp` one cycle after the command that caused it. A wrong stored entry stays hidden until the matching pop or return, which may come many commands later. For that reason the stimulus alternates deep pushes with unwinding pops and returns, so every written entry is eventually read back. Boundary errors surface on `err` and on missing strobes in the following cycle, and the directed fills drive each pointer into both limits.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  localparam int unsigned N_LANES = 2;
  localparam int unsigned LANE_DATA = 0;
  localparam int unsigned LANE_CALL = 1;
endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read port holds its value between reads.
  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/stk_lane.sv
module stk_lane #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PTR_W-1:0]  ptr,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              fault
);
  localparam logic [PTR_W-1:0] PTR_TOP = '1;
  localparam logic [PTR_W-1:0] PTR_BOT = '0;

  logic             at_bot, at_top;
  logic [PTR_W-1:0] ptr_up;

  assign at_bot  = (ptr == PTR_BOT);
  assign at_top  = (ptr == PTR_TOP);
  assign ptr_up  = ptr + 1'b1;
  assign push_ok = push && !at_bot;
  assign pop_ok  = pop && !at_top;
  assign fault   = (push && at_bot) || (pop && at_top);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= PTR_TOP;
    else if (push_ok) ptr <= ptr - 1'b1;
    else if (pop_ok)  ptr <= ptr_up;
  end

  stk_ram #(.DATA_W(DATA_W), .ADDR_W(PTR_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (push_ok),
    .waddr (ptr),
    .wdata (wdata),
    .re    (pop_ok),
    .raddr (ptr_up),
    .rdata (rdata)
  );
endmodule

// File: rtl/dual_stack_unit.sv
module dual_stack_unit #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned BANK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [1:0]              cmd_op,
  input  logic [DATA_W-1:0]       operand,
  input  logic [DATA_W-1:0]       cur_pc,
  input  logic [DATA_W-1:0]       target,
  input  logic [BANK_W-1:0]       bank_num,
  output logic [DATA_W-1:0]       pop_data,
  output logic                    pop_valid,
  output logic [DATA_W-1:0]       pc_next,
  output logic                    pc_load,
  output logic                    err,
  output logic [PTR_W-1:0]        dsp,
  output logic [PTR_W-1:0]        csp,
  output logic [BANK_W+PTR_W-1:0] bank_view
);
  import stk_pkg::*;

  stk_op_e op;
  assign op = stk_op_e'(cmd_op);

  logic              l_push  [N_LANES];
  logic              l_pop   [N_LANES];
  logic [DATA_W-1:0] l_wdata [N_LANES];
  logic [DATA_W-1:0] l_rdata [N_LANES];
  logic [PTR_W-1:0]  l_ptr   [N_LANES];
  logic              l_pshok [N_LANES];
  logic              l_popok [N_LANES];
  logic              l_fault [N_LANES];

  always_comb begin
    l_push[LANE_DATA]  = cmd_valid && (op == OP_PUSH);
    l_pop[LANE_DATA]   = cmd_valid && (op == OP_POP);
    l_wdata[LANE_DATA] = operand;
    l_push[LANE_CALL]  = cmd_valid && (op == OP_CALL);
    l_pop[LANE_CALL]   = cmd_valid && (op == OP_RET);
    l_wdata[LANE_CALL] = cur_pc;
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    stk_lane #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (l_push[g]),
      .pop     (l_pop[g]),
      .wdata   (l_wdata[g]),
      .rdata   (l_rdata[g]),
      .ptr     (l_ptr[g]),
      .push_ok (l_pshok[g]),
      .pop_ok  (l_popok[g]),
      .fault   (l_fault[g])
    );
  end

  // Result strobes and the target capture for calls.
  logic              ret_sel_q;
  logic [DATA_W-1:0] call_tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_valid  <= 1'b0;
      pc_load    <= 1'b0;
      err        <= 1'b0;
      ret_sel_q  <= 1'b0;
      call_tgt_q <= '0;
    end else begin
      pop_valid <= l_popok[LANE_DATA];
      pc_load   <= l_pshok[LANE_CALL] || l_popok[LANE_CALL];
      err       <= l_fault[LANE_DATA] || l_fault[LANE_CALL];
      if (l_pshok[LANE_CALL]) begin
        call_tgt_q <= target;
        ret_sel_q  <= 1'b0;
      end else if (l_popok[LANE_CALL]) begin
        ret_sel_q  <= 1'b1;
      end
    end
  end

  assign pop_data  = l_rdata[LANE_DATA];
  assign pc_next   = ret_sel_q ? l_rdata[LANE_CALL] : call_tgt_q;
  assign dsp       = l_ptr[LANE_DATA];
  assign csp       = l_ptr[LANE_CALL];
  assign bank_view = {bank_num, dsp};
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PTR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [DATA_W-1:0] target,
  input logic              pop_valid,
  input logic              pc_load,
  input logic              err,
  input logic [DATA_W-1:0] pop_data,
  input logic [DATA_W-1:0] pc_next,
  input logic [PTR_W-1:0]  dsp,
  input logic [PTR_W-1:0]  csp
);
  localparam logic [PTR_W-1:0] TOP = '1;
  localparam logic [PTR_W-1:0] BOT = '0;

  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd0 && dsp != BOT |=> dsp == $past(dsp) - 1'b1 && !err);

  p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd1 && dsp != TOP |=> pop_valid && dsp == $past(dsp) + 1'b1);

  p_call_tgt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd2 && csp != BOT |=> pc_load && pc_next == $past(target));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && ((cmd_op == 2'd0 && dsp == BOT) || (cmd_op == 2'd2 && csp == BOT))
    |=> err && !pc_load && $stable(dsp) && $stable(csp));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && ((cmd_op == 2'd1 && dsp == TOP) || (cmd_op == 2'd3 && csp == TOP))
    |=> err && !pop_valid && !pc_load && $stable(dsp) && $stable(csp));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !err && !pop_valid && !pc_load && $stable(dsp) && $stable(csp)
                   && $stable(pop_data) && $stable(pc_next));

  p_lane_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_op[1] |=> $stable(csp) && $stable(pc_next));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_valid, pc_load}));
endmodule

bind dual_stack_unit stk_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_stk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .target    (target),
  .pop_valid (pop_valid),
  .pc_load   (pc_load),
  .err       (err),
  .pop_data  (pop_data),
  .pc_next   (pc_next),
  .dsp       (dsp),
  .csp       (csp)
);

// File: tb/test_dual_stack_unit.sv
module test_dual_stack_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [15:0] operand, cur_pc, target;
  logic [7:0]  bank_num;
  logic [15:0] pop_data, pc_next, bank_view;
  logic        pop_valid, pc_load, err;
  logic [7:0]  dsp, csp;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_stack_unit i_dual_stack_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .operand(operand), .cur_pc(cur_pc), .target(target), .bank_num(bank_num),
    .pop_data(pop_data), .pop_valid(pop_valid), .pc_next(pc_next),
    .pc_load(pc_load), .err(err), .dsp(dsp), .csp(csp), .bank_view(bank_view)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench reference model
  logic [15:0] m_ds [256];
  logic [15:0] m_cs [256];
  logic [7:0]  m_dsp, m_csp;
  logic [15:0] m_pop, m_pc;
  logic        m_pv, m_pl, m_err;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic v, input logic [1:0] op, input logic [7:0] dp, input logic [7:0] cp);
    if (!v) return "R9";
    case (op)
      2'd0: return (dp == 8'h00) ? "R6" : "R2";
      2'd1: return (dp == 8'hFF) ? "R7" : "R3";
      2'd2: return (cp == 8'h00) ? "R6" : "R4";
      default: return (cp == 8'hFF) ? "R7" : "R5";
    endcase
  endfunction

  task automatic model(input logic v, input logic [1:0] op);
    m_pv = 0; m_pl = 0; m_err = 0;
    if (v) begin
      case (op)
        2'd0: if (m_dsp == 8'h00) m_err = 1;
              else begin m_ds[m_dsp] = operand; m_dsp = m_dsp - 1; end
        2'd1: if (m_dsp == 8'hFF) m_err = 1;
              else begin m_pop = m_ds[m_dsp + 8'd1]; m_dsp = m_dsp + 1; m_pv = 1; end
        2'd2: if (m_csp == 8'h00) m_err = 1;
              else begin m_cs[m_csp] = cur_pc; m_csp = m_csp - 1; m_pc = target; m_pl = 1; end
        default: if (m_csp == 8'hFF) m_err = 1;
              else begin m_pc = m_cs[m_csp + 8'd1]; m_csp = m_csp + 1; m_pl = 1; end
      endcase
    end
  endtask

  // Drive at a falling edge, check at the next falling edge.
  task automatic step(input logic v, input logic [1:0] op, input logic [15:0] d,
                      input logic [15:0] pc, input logic [15:0] tg);
    string r;
    r = req_of(v, op, m_dsp, m_csp);
    cmd_valid = v; cmd_op = op; operand = d; cur_pc = pc; target = tg;
    bank_num = 8'($urandom);
    model(v, op);
    @(negedge clk);
    chk(r, "pop_valid", 32'(pop_valid), 32'(m_pv));
    chk(r, "pc_load", 32'(pc_load), 32'(m_pl));
    chk(r, "err", 32'(err), 32'(m_err));
    chk(r, "dsp R10", 32'(dsp), 32'(m_dsp));
    chk(r, "csp R10", 32'(csp), 32'(m_csp));
    chk(r, "pop_data", 32'(pop_data), 32'(m_pop));
    chk(r, "pc_next", 32'(pc_next), 32'(m_pc));
    chk("R8", "bank_view", 32'(bank_view), {16'h0, bank_num, m_dsp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 0; cmd_valid = 0; cmd_op = 0; operand = 0; cur_pc = 0; target = 0; bank_num = 8'h5A;
    m_dsp = 8'hFF; m_csp = 8'hFF; m_pop = 0; m_pc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "dsp", 32'(dsp), 32'hFF);
    chk("R1", "csp", 32'(csp), 32'hFF);
    chk("R1", "strobes", {29'h0, pop_valid, pc_load, err}, 32'h0);
    chk("R1", "pop_data", 32'(pop_data), 32'h0);
    chk("R1", "pc_next", 32'(pc_next), 32'h0);
    rst_n = 1;

    // R7 underflow on empty stacks
    step(1, 2'd1, 16'h0, 16'h0, 16'h0);
    step(1, 2'd3, 16'h0, 16'h0, 16'h0);
    // Fill the data stack to overflow (R2, R6), then drain to underflow (R3, R7)
    for (int i = 0; i < 257; i++) step(1, 2'd0, 16'(16'hA000 + i), 16'h0, 16'h0);
    step(0, 2'd1, 16'h0, 16'h0, 16'h0);
    for (int i = 0; i < 257; i++) step(1, 2'd1, 16'h0, 16'h0, 16'h0);
    // Fill the call stack to overflow (R4, R6), then unwind (R5, R7)
    for (int i = 0; i < 257; i++) step(1, 2'd2, 16'h0, 16'(16'h1000 + i), 16'(16'h8000 ^ i));
    step(0, 2'd3, 16'h0, 16'h0, 16'h0);
    for (int i = 0; i < 257; i++) step(1, 2'd3, 16'h0, 16'h0, 16'h0);

    // Constrained random mix with phases of growth and unwinding
    for (int ph = 0; ph < 40; ph++) begin
      for (int i = 0; i < 150; i++) begin
        logic [1:0] op;
        logic v;
        v = ($urandom % 6) != 0;
        op = 2'($urandom % 4);
        if ((ph % 2) == 0 && ($urandom % 3) != 0) op = {op[1], 1'b0};
        if ((ph % 2) == 1 && ($urandom % 3) != 0) op = {op[1], 1'b1};
        step(v, op, 16'($urandom), 16'($urandom), 16'($urandom));
      end
    end

    step(0, 2'd0, 16'h0, 16'h0, 16'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule